// File: doc/BRIEF.md
# Windowed GPIO Port Register Bank

This block is the register core of a general-purpose I/O expander. A byte-wide register port (7-bit address, write strobe with write data, read strobe with read data) reaches a configuration register, seven mode registers that give each of 28 I/O ports (numbered 4 to 31) a two-bit mode code, and one output latch per port. From the stored state the block drives an output enable, an output value and a pullup enable for every port, and it samples the live input level of every port for readback.

Port data is not laid out in fixed bytes. Each port can be reached alone through its own address, or as part of an eight-port window that can start at any port number. Windows overlap freely and need no alignment, so a host can update any run of eight neighbouring ports in one write. A shutdown bit forces every pad to a quiet input state while all stored settings are kept and stay writable. The highest port, when set as an output, carries an alert level that a separate change detector supplies. The serial front end and that detector sit outside this block.

Top module: `gpio_window_bank`

## Requirements
- R1: After reset every mode register (0x09 to 0x0F) reads 0xAA, the configuration register (0x04) reads 0x00, every output latch is 0, and no port has its output or pullup enabled.
- R2: Register 0x09+k holds the mode codes of ports 4+4k to 7+4k, two bits per port with the lowest-numbered port in bits 1:0; code 01 enables the output, 10 is an input without pullup, 11 is an input with pullup, and 00 neither drives nor pulls up. Output and pullup are never enabled together.
- R3: Configuration register 0x04 stores bit 0 as the run bit (1 = normal, 0 = shutdown) and bit 7 as the monitor bit, which is presented on `cfg_monitor`; its other bits read as 0.
- R4: With the run bit at 0 every output and pullup enable is 0; mode and latch registers keep their values and accept writes, and setting the run bit again restores the drive the stored state selects.
- R5: Address 0x20+N writes data bit 0 into the latch of port N and reads that port's level in bit 0 with bits 7:1 at 0; for N below 4 a write changes nothing and a read returns 0x00.
- R6: Address 0x40+N maps data bit i to port N+i for i = 0..7 at any N from 0 to 31; bits that land on a port below 4 or above 31 are ignored on write and read as 0.
- R7: A read of a port whose mode code is 01 returns its output latch; a read of a port with any other code returns the current level on `pad_in` for that port.
- R8: Writes to address 0x07, to any other address outside 0x04, 0x09 to 0x0F and 0x20 to 0x5F are ignored, and reads of them return 0x00.
- R9: Port 31, when its output is enabled, drives `alert_level_in` instead of its latch; any port whose output is not enabled drives 0 on `pad_out`.
- R10: `reg_rdata` takes the addressed value at the clock edge where `reg_rd` is high and holds it in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 7 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, registered |
| pad_in | input | 32 | Sampled level of each port (bits 0 to 3 unused) |
| alert_level_in | input | 1 | Level driven on port 31 when it is an output |
| pad_oe | output | 32 | Output enable per port |
| pad_out | output | 32 | Output value per port |
| pad_pu | output | 32 | Pullup enable per port |
| cfg_monitor | output | 1 | Stored monitor bit |

## Verification
On every cycle the assertions check the pad-side invariants: quiet pads during shutdown, output and pullup never both on, nothing driven on the virtual ports, the alert level on port 31, a held read value between reads, and that ignored or virtual-port writes leave all stored state untouched. The address arithmetic of the windows, the mode-code packing, the choice between latch and live level on readback and the restore after shutdown are shown only by the bench, which sweeps every single-port and eight-port window address and every unmapped address against a model of the register map.

// File: rtl/gpio_win_pkg.sv
package gpio_win_pkg;

  localparam int PORT_SPACE = 32;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int WIN_SPAN   = 8;
  localparam int BASE_W     = $clog2(PORT_SPACE);
  localparam int MODE_REGS  = PORT_SPACE / 4;

  localparam logic [ADDR_W-1:0] ADDR_CFG       = 7'h04;
  localparam logic [ADDR_W-1:0] ADDR_MODE_LO   = 7'h09;
  localparam logic [ADDR_W-1:0] ADDR_MODE_HI   = 7'h0F;
  localparam logic [1:0]        SEL_SINGLE     = 2'b01;
  localparam logic [1:0]        SEL_OCTET      = 2'b10;
  localparam logic [DATA_W-1:0] MODE_RST_BYTE  = 8'hAA;

  typedef enum logic [1:0] {
    MODE_RSVD  = 2'b00,
    MODE_OUT   = 2'b01,
    MODE_IN    = 2'b10,
    MODE_IN_PU = 2'b11
  } port_mode_e;

  // Mask of the ports that physically exist.
  function automatic logic [PORT_SPACE-1:0] port_mask(int first, int last);
    logic [PORT_SPACE-1:0] m;
    m = '0;
    for (int p = 0; p < PORT_SPACE; p++) begin
      if (p >= first && p <= last) m[p] = 1'b1;
    end
    return m;
  endfunction

  // Collect eight consecutive port levels starting at base.
  function automatic logic [DATA_W-1:0] octet_gather(logic [PORT_SPACE-1:0] view,
                                                      logic [BASE_W-1:0] base);
    logic [DATA_W-1:0] g;
    int idx;
    g = '0;
    for (int i = 0; i < WIN_SPAN; i++) begin
      idx = int'(base) + i;
      if (idx < PORT_SPACE) g[i] = view[idx[BASE_W-1:0]];
    end
    return g;
  endfunction

  // Distance of a port from the window base (wraps when base is above it).
  function automatic logic [BASE_W:0] window_offset(int port, logic [BASE_W-1:0] base);
    return (BASE_W+1)'(port) - {1'b0, base};
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_win_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_cfg,
  output logic              hit_mode,
  output logic              hit_single,
  output logic              hit_octet,
  output logic              hit_none,
  output logic [2:0]        mode_idx,
  output logic [BASE_W-1:0] win_base
);

  assign hit_cfg    = (addr == ADDR_CFG);
  assign hit_mode   = (addr >= ADDR_MODE_LO) && (addr <= ADDR_MODE_HI);
  assign hit_single = (addr[ADDR_W-1:BASE_W] == SEL_SINGLE);
  assign hit_octet  = (addr[ADDR_W-1:BASE_W] == SEL_OCTET);
  assign hit_none   = !(hit_cfg || hit_mode || hit_single || hit_octet);
  assign mode_idx   = addr[2:0];
  assign win_base   = addr[BASE_W-1:0];

endmodule

// File: rtl/gpio_mode_store.sv
module gpio_mode_store
  import gpio_win_pkg::*;
#(
  parameter int FIRST_PORT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_mode,
  input  logic [2:0]              mode_idx,
  input  logic [DATA_W-1:0]       wdata,
  output logic [2*PORT_SPACE-1:0] mode_flat
);

  localparam int FIRST_REG = FIRST_PORT / 4;

  for (genvar k = 0; k < MODE_REGS; k++) begin : g_reg
    if (k >= FIRST_REG) begin : g_live
      logic [DATA_W-1:0] byte_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                                  byte_q <= MODE_RST_BYTE;
        else if (wr_mode && mode_idx == 3'(k))       byte_q <= wdata;
      end
      assign mode_flat[DATA_W*k +: DATA_W] = byte_q;
    end else begin : g_fixed
      assign mode_flat[DATA_W*k +: DATA_W] = MODE_RST_BYTE;
    end
  end

endmodule

// File: rtl/gpio_latch_bank.sv
module gpio_latch_bank
  import gpio_win_pkg::*;
#(
  parameter int FIRST_PORT = 4,
  parameter int LAST_PORT  = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_single,
  input  logic                  wr_octet,
  input  logic [BASE_W-1:0]     win_base,
  input  logic [DATA_W-1:0]     wdata,
  output logic [PORT_SPACE-1:0] latch_q
);

  for (genvar p = 0; p < PORT_SPACE; p++) begin : g_port
    if (p >= FIRST_PORT && p <= LAST_PORT) begin : g_live
      logic            bit_q;
      logic [BASE_W:0] off;
      assign off = window_offset(p, win_base);
      always_ff @(posedge clk) begin
        if (!rst_n)
          bit_q <= 1'b0;
        else if (wr_single && win_base == BASE_W'(p))
          bit_q <= wdata[0];
        else if (wr_octet && off < (BASE_W+1)'(WIN_SPAN))
          bit_q <= wdata[off[2:0]];
      end
      assign latch_q[p] = bit_q;
    end else begin : g_virtual
      assign latch_q[p] = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_win_pkg::*;
#(
  parameter int FIRST_PORT = 4,
  parameter int LAST_PORT  = 31,
  parameter int ALERT_PORT = 31
) (
  input  logic                    run_en,
  input  logic [2*PORT_SPACE-1:0] mode_flat,
  input  logic [PORT_SPACE-1:0]   latch_q,
  input  logic                    alert_level_in,
  output logic [PORT_SPACE-1:0]   pad_oe,
  output logic [PORT_SPACE-1:0]   pad_out,
  output logic [PORT_SPACE-1:0]   pad_pu
);

  localparam logic [PORT_SPACE-1:0] EXIST_MASK = port_mask(FIRST_PORT, LAST_PORT);
  localparam logic [PORT_SPACE-1:0] ALERT_BIT  = PORT_SPACE'(1) << ALERT_PORT;

  logic [PORT_SPACE-1:0] is_out, is_pu, drive_val;

  for (genvar p = 0; p < PORT_SPACE; p++) begin : g_mode
    port_mode_e m;
    assign m        = port_mode_e'(mode_flat[2*p +: 2]);
    assign is_out[p] = (m == MODE_OUT);
    assign is_pu[p]  = (m == MODE_IN_PU);
  end

  assign drive_val = (latch_q & ~ALERT_BIT) | (alert_level_in ? ALERT_BIT : '0);
  assign pad_oe    = {PORT_SPACE{run_en}} & EXIST_MASK & is_out;
  assign pad_pu    = {PORT_SPACE{run_en}} & EXIST_MASK & is_pu;
  assign pad_out   = pad_oe & drive_val;

endmodule

// File: rtl/gpio_window_bank.sv
module gpio_window_bank
  import gpio_win_pkg::*;
#(
  parameter int FIRST_PORT = 4,
  parameter int LAST_PORT  = 31,
  parameter int ALERT_PORT = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic                  reg_rd,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [PORT_SPACE-1:0] pad_in,
  input  logic                  alert_level_in,
  output logic [PORT_SPACE-1:0] pad_oe,
  output logic [PORT_SPACE-1:0] pad_out,
  output logic [PORT_SPACE-1:0] pad_pu,
  output logic                  cfg_monitor
);

  localparam logic [PORT_SPACE-1:0] EXIST_MASK = port_mask(FIRST_PORT, LAST_PORT);

  logic              hit_cfg, hit_mode, hit_single, hit_octet, hit_none;
  logic [2:0]        mode_idx;
  logic [BASE_W-1:0] win_base;

  gpio_addr_decode u_dec (
    .addr       (reg_addr),
    .hit_cfg    (hit_cfg),
    .hit_mode   (hit_mode),
    .hit_single (hit_single),
    .hit_octet  (hit_octet),
    .hit_none   (hit_none),
    .mode_idx   (mode_idx),
    .win_base   (win_base)
  );

  // Named write events, also watched by the checker.
  logic wr_cfg, wr_mode, wr_single, wr_octet, wr_ignored, wr_virtual_single;
  assign wr_cfg            = reg_wr && hit_cfg;
  assign wr_mode           = reg_wr && hit_mode;
  assign wr_single         = reg_wr && hit_single;
  assign wr_octet          = reg_wr && hit_octet;
  assign wr_ignored        = reg_wr && hit_none;
  assign wr_virtual_single = wr_single && !EXIST_MASK[win_base];

  logic cfg_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_run     <= 1'b0;
      cfg_monitor <= 1'b0;
    end else if (wr_cfg) begin
      cfg_run     <= reg_wdata[0];
      cfg_monitor <= reg_wdata[7];
    end
  end

  logic [2*PORT_SPACE-1:0] mode_flat;
  gpio_mode_store #(.FIRST_PORT(FIRST_PORT)) u_modes (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mode   (wr_mode),
    .mode_idx  (mode_idx),
    .wdata     (reg_wdata),
    .mode_flat (mode_flat)
  );

  logic [PORT_SPACE-1:0] latch_q;
  gpio_latch_bank #(.FIRST_PORT(FIRST_PORT), .LAST_PORT(LAST_PORT)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_single (wr_single),
    .wr_octet  (wr_octet),
    .win_base  (win_base),
    .wdata     (reg_wdata),
    .latch_q   (latch_q)
  );

  gpio_pad_drive #(.FIRST_PORT(FIRST_PORT), .LAST_PORT(LAST_PORT),
                   .ALERT_PORT(ALERT_PORT)) u_drive (
    .run_en         (cfg_run),
    .mode_flat      (mode_flat),
    .latch_q        (latch_q),
    .alert_level_in (alert_level_in),
    .pad_oe         (pad_oe),
    .pad_out        (pad_out),
    .pad_pu         (pad_pu)
  );

  // Readback view: latch for outputs, live level otherwise.
  logic [PORT_SPACE-1:0] out_sel, port_view;
  for (genvar p = 0; p < PORT_SPACE; p++) begin : g_view
    assign out_sel[p] = (port_mode_e'(mode_flat[2*p +: 2]) == MODE_OUT);
  end
  assign port_view = EXIST_MASK & ((out_sel & latch_q) | (~out_sel & pad_in));

  logic [DATA_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (hit_cfg)         rd_val = {cfg_monitor, 6'b0, cfg_run};
    else if (hit_mode)   rd_val = mode_flat[{mode_idx, 3'b000} +: DATA_W];
    else if (hit_single) rd_val = {7'b0, port_view[win_base]};
    else if (hit_octet)  rd_val = octet_gather(port_view, win_base);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

endmodule

// File: rtl/gpio_window_chk.sv
module gpio_window_chk
  import gpio_win_pkg::*;
#(
  parameter int FIRST_PORT = 4,
  parameter int LAST_PORT  = 31,
  parameter int ALERT_PORT = 31
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_rd,
  input logic [DATA_W-1:0]       reg_rdata,
  input logic [PORT_SPACE-1:0]   pad_oe,
  input logic [PORT_SPACE-1:0]   pad_out,
  input logic [PORT_SPACE-1:0]   pad_pu,
  input logic                    alert_level_in,
  input logic                    run_en,
  input logic                    cfg_monitor,
  input logic                    wr_ignored,
  input logic                    wr_virtual_single,
  input logic [2*PORT_SPACE-1:0] mode_flat,
  input logic [PORT_SPACE-1:0]   latch_q
);

  localparam logic [PORT_SPACE-1:0] EXIST_MASK = port_mask(FIRST_PORT, LAST_PORT);

  // R4
  shutdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (pad_oe == '0 && pad_pu == '0));

  // R2
  oe_pu_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);

  // R5
  virtual_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_pu | pad_out) & ~EXIST_MASK) == '0);

  // R9
  alert_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[ALERT_PORT] |-> (pad_out[ALERT_PORT] == alert_level_in));

  // R9
  undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  // R8
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> ($stable(mode_flat) && $stable(latch_q) &&
                    $stable(run_en) && $stable(cfg_monitor)));

  // R5
  virtual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_virtual_single |=> $stable(latch_q));

endmodule

bind gpio_window_bank gpio_window_chk #(
  .FIRST_PORT(FIRST_PORT), .LAST_PORT(LAST_PORT), .ALERT_PORT(ALERT_PORT)
) chk_i (
  .clk               (clk),
  .rst_n             (rst_n),
  .reg_rd            (reg_rd),
  .reg_rdata         (reg_rdata),
  .pad_oe            (pad_oe),
  .pad_out           (pad_out),
  .pad_pu            (pad_pu),
  .alert_level_in    (alert_level_in),
  .run_en            (cfg_run),
  .cfg_monitor       (cfg_monitor),
  .wr_ignored        (wr_ignored),
  .wr_virtual_single (wr_virtual_single),
  .mode_flat         (mode_flat),
  .latch_q           (latch_q)
);

// File: tb/gpio_window_bank_tb.sv
module gpio_window_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic [31:0] pad_in = 32'hA5C3_96E1;
  logic        alert_level_in = 1'b0;
  logic [31:0] pad_oe, pad_out, pad_pu;
  logic        cfg_monitor;

  always #5 clk = ~clk;

  gpio_window_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .alert_level_in(alert_level_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu), .cfg_monitor(cfg_monitor)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // Model of the register map.
  int m_mode[32];
  bit m_latch[32];
  bit m_run = 0, m_mon = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit port_level(int q);
    if (q < 4 || q > 31) return 1'b0;
    if (m_mode[q] == 1) return m_latch[q];
    return pad_in[q];
  endfunction

  function automatic logic [7:0] exp_read(int a);
    logic [7:0] v = 8'h00;
    if (a == 4) v = {m_mon, 6'b0, m_run};
    else if (a >= 9 && a <= 15) begin
      for (int j = 0; j < 4; j++) v = v | 8'((m_mode[(a - 8) * 4 + j] & 3) << (2 * j));
    end else if (a >= 32 && a < 64) v = {7'b0, port_level(a - 32)};
    else if (a >= 64 && a < 96) begin
      for (int i = 0; i < 8; i++) v[i] = port_level(a - 64 + i);
    end
    return v;
  endfunction

  function automatic void model_write(int a, logic [7:0] d);
    if (a == 4) begin m_run = d[0]; m_mon = d[7]; end
    else if (a >= 9 && a <= 15) begin
      for (int j = 0; j < 4; j++) m_mode[(a - 8) * 4 + j] = int'((d >> (2 * j)) & 8'd3);
    end else if (a >= 32 && a < 64) begin
      if (a - 32 >= 4) m_latch[a - 32] = d[0];
    end else if (a >= 64 && a < 96) begin
      for (int i = 0; i < 8; i++)
        if (a - 64 + i >= 4 && a - 64 + i <= 31) m_latch[a - 64 + i] = d[i];
    end
  endfunction

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    reg_addr = 7'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = 7'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_check(string req, int a);
    logic [7:0] d;
    rd(a, d);
    check(req, {24'b0, d}, {24'b0, exp_read(a)});
  endtask

  task automatic check_pads(string req);
    logic [31:0] eoe = '0, epu = '0, eout = '0;
    for (int p = 4; p < 32; p++) begin
      eoe[p]  = m_run && m_mode[p] == 1;
      epu[p]  = m_run && m_mode[p] == 3;
      eout[p] = eoe[p] && ((p == 31) ? alert_level_in : m_latch[p]);
    end
    check({req, " oe"}, pad_oe, eoe);
    check({req, " pu"}, pad_pu, epu);
    check({req, " out"}, pad_out, eout);
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, held;
    for (int p = 0; p < 32; p++) begin m_mode[p] = 2; m_latch[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_pads("R1");
    for (int a = 9; a <= 15; a++) rd_check("R1 mode reset", a);
    rd_check("R1 cfg reset", 4);
    for (int a = 64; a < 96; a += 8) rd_check("R1 latch reset", a);

    // R3: configuration bits
    wr(4, 8'hFF);
    rd_check("R3 cfg", 4);
    check("R3 monitor", {31'b0, cfg_monitor}, 32'd1);
    wr(4, 8'h01);
    check("R3 monitor clear", {31'b0, cfg_monitor}, 32'd0);

    // R2: mode code packing and decoding, all codes
    for (int k = 1; k <= 7; k++) begin
      logic [7:0] b = '0;
      for (int j = 0; j < 4; j++) b = b | 8'(((4 * k + j) * 7 + 3) % 4 << (2 * j));
      wr(8 + k, b);
    end
    for (int a = 9; a <= 15; a++) rd_check("R2 mode readback", a);
    check_pads("R2");

    // R5, R7: single-port window sweep
    for (int n = 0; n < 32; n++) wr(32 + n, 8'hFE | 8'((n * 5 >> 1) & 1));
    check_pads("R5 after single writes");
    for (int n = 0; n < 32; n++) rd_check("R5 R7 single read", 32 + n);
    pad_in = ~pad_in;
    for (int n = 0; n < 32; n++) rd_check("R7 live level", 32 + n);

    // R6: eight-port window at every base
    for (int n = 0; n < 32; n++) begin
      wr(64 + n, 8'((n * 37 + 11) & 8'hFF));
      check_pads("R6 octet write");
    end
    for (int n = 0; n < 32; n++) rd_check("R6 octet read", 64 + n);

    // R8: reserved and unmapped addresses
    for (int a = 0; a < 128; a++) begin
      if (!(a == 4 || (a >= 9 && a <= 15) || (a >= 32 && a < 96))) begin
        wr(a, 8'hFF);
        rd_check("R8 unmapped read", a);
      end
    end
    rd_check("R8 cfg kept", 4);
    for (int a = 9; a <= 15; a++) rd_check("R8 modes kept", a);
    for (int a = 64; a < 96; a += 8) rd_check("R8 latches kept", a);
    check_pads("R8");

    // R4: shutdown keeps state and stays writable
    wr(4, 8'h80);
    check_pads("R4 shutdown");
    wr(15, 8'h55);
    wr(8'h58, 8'h3C);
    check_pads("R4 shutdown after writes");
    rd_check("R4 mode written in shutdown", 15);
    rd_check("R4 latch written in shutdown", 8'h58);
    wr(4, 8'h01);
    check_pads("R4 restore");

    // R9: alert level on port 31
    wr(63, 8'h00);
    alert_level_in = 1'b1;
    #1 check_pads("R9 alert high");
    alert_level_in = 1'b0;
    #1 check_pads("R9 alert low");
    wr(63, 8'h01);
    check_pads("R9 latch ignored");
    rd_check("R9 latch readback", 63);

    // R10: read data holds without a read strobe
    rd(15, held);
    @(negedge clk); reg_addr = 7'h04;
    repeat (3) @(negedge clk);
    check("R10 hold", {24'b0, reg_rdata}, {24'b0, held});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule